// File: doc/BRIEF.md
# Single-Bus Control Step Sequencer

This block is the hardwired control unit of a small processor in which every register, the ALU and the memory interface hang off one shared internal bus. It walks through numbered control steps and, in each step, raises the one-cycle strobes that the datapath needs. These strobes are the enable of the one register allowed to drive the bus, the load enables of the registers that capture the bus, a memory read request, an ALU operation select, a hold that freezes the step while memory is busy, and an end-of-instruction strobe that restarts the count.

Every instruction starts with the same three fetch steps. The first step issues a read at the program counter and starts the counter increment in the ALU. The second step writes the incremented value back while the block waits for memory. The third step moves the fetched word into the instruction register. From step 4 onward the sequence depends on the opcode taken from the instruction register. A register move takes one execute step. An add takes three steps, because the ALU sees one operand through a holding register Y and the other on the bus. A load from a direct address runs its own memory read and wait before writing the destination register. Any other opcode ends the instruction at once.

Top module: `bus_seq_top`

## Requirements
- R1: Synchronous active-high `rst` sets `curStep` to 1. While `rst` is high every strobe output (`busDrv`, `loadEn`, `memRead`, `aluOp`, `waitMem`, `stepEnd`) is 0.
- R2: Step 1 raises `busDrv[0]` (program counter), `loadEn[1]` (memory address register), `loadEn[4]` (result register Z), `memRead`, and `aluOp`=2 (increment). Step 1 always advances to step 2.
- R3: Step 2 raises `busDrv[2]` (Z) and `loadEn[0]` (program counter). While `memReady` is 0 it raises `waitMem` and the step is held. The sequencer leaves step 2 in the first cycle in which `memReady` is 1.
- R4: Step 3 raises `busDrv[1]` (memory data register) and `loadEn[2]` (instruction register), then advances to step 4, where the opcode is decoded.
- R5: Opcode 1 (move): step 4 raises `busDrv[3]` (source register), `loadEn[5]` (destination register) and `stepEnd`.
- R6: Opcode 2 (add): step 4 raises `busDrv[4]` (destination register) and `loadEn[3]` (Y). Step 5 raises `busDrv[3]`, `loadEn[4]` and `aluOp`=1 (add). Step 6 raises `busDrv[2]`, `loadEn[5]` and `stepEnd`.
- R7: Opcode 3 (direct load): step 4 raises `busDrv[5]` (instruction address field), `loadEn[1]` and `memRead`. Step 5 raises no bus strobe and is held with `waitMem` high while `memReady` is 0. Step 6 raises `busDrv[1]`, `loadEn[5]` and `stepEnd`.
- R8: Any other opcode value is a no-op: step 4 raises only `stepEnd`.
- R9: At most one bit of `busDrv` is high in any cycle.
- R10: In the cycle after `stepEnd` is high, `curStep` is 1.
- R11: `aluOp` is 0 in every step not named above as add or increment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| opcode | input | OPW | Opcode field of the instruction register |
| memReady | input | 1 | Memory has completed the pending read |
| busDrv | output | 6 | Bus output enables: 0 PC, 1 MDR, 2 Z, 3 source reg, 4 destination reg, 5 IR address field |
| loadEn | output | 6 | Load enables: 0 PC, 1 MAR, 2 IR, 3 Y, 4 Z, 5 destination reg |
| memRead | output | 1 | Memory read request |
| aluOp | output | 2 | ALU select: 0 none, 1 add, 2 increment |
| waitMem | output | 1 | Step held for memory ready |
| stepEnd | output | 1 | Last step of the instruction; restart at step 1 |
| curStep | output | STEPW | Current control step number |

## Verification
The bench builds the block with its defaults, OPW=4 and STEPW=3. With a 4-bit opcode, the undefined values 0, 9 and 15 can be fed next to the three defined instructions, and a 3-bit counter holds every step through step 6. It runs an instruction mix under three memory-ready patterns: always ready, ready every third cycle, and ready once in six cycles. These patterns exercise zero-wait and multi-cycle holds in both the fetch wait and the load wait, and the bench also applies a reset in the middle of an instruction.

// File: rtl/ctrl_pkg.sv
package ctrl_pkg;
  localparam int NDRV = 6;
  localparam int NLD  = 6;

  // bus driver bit positions
  localparam int DRV_PC   = 0;
  localparam int DRV_MDR  = 1;
  localparam int DRV_Z    = 2;
  localparam int DRV_SRC  = 3;
  localparam int DRV_DST  = 4;
  localparam int DRV_ADDR = 5;

  // load enable bit positions
  localparam int LD_PC  = 0;
  localparam int LD_MAR = 1;
  localparam int LD_IR  = 2;
  localparam int LD_Y   = 3;
  localparam int LD_Z   = 4;
  localparam int LD_DST = 5;

  typedef enum logic [1:0] {
    ALU_NONE = 2'd0,
    ALU_ADD  = 2'd1,
    ALU_INC  = 2'd2
  } aluOp_e;

  typedef struct packed {
    logic [NDRV-1:0] drv;
    logic [NLD-1:0]  load;
    logic            memRead;
    aluOp_e          alu;
    logic            hold;
    logic            stepEnd;
  } strobes_t;
endpackage

// File: rtl/step_counter.sv
module step_counter #(
  parameter int STEPW = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             hold,
  input  logic             stepEnd,
  output logic [STEPW-1:0] step
);
  localparam logic [STEPW-1:0] FIRST_STEP = STEPW'(1);
  localparam logic [STEPW-1:0] LAST_STEP  = STEPW'(6);

  always_ff @(posedge clk) begin
    if (rst)          step <= FIRST_STEP;
    else if (stepEnd) step <= FIRST_STEP;
    else if (!hold)   step <= step + STEPW'(1);
  end

  AST_HOLD_FREEZES: assert property (@(posedge clk) disable iff (rst)
    hold && !stepEnd |=> $stable(step)); // R3
  AST_END_RESTARTS: assert property (@(posedge clk) disable iff (rst)
    stepEnd |=> step == FIRST_STEP); // R10
  AST_STEP_RANGE: assert property (@(posedge clk) disable iff (rst)
    step >= FIRST_STEP && step <= LAST_STEP); // R1
endmodule

// File: rtl/step_decoder.sv
module step_decoder
  import ctrl_pkg::*;
#(
  parameter int              OPW    = 4,
  parameter int              STEPW  = 3,
  parameter logic [OPW-1:0]  OP_MOV = OPW'(1),
  parameter logic [OPW-1:0]  OP_ADD = OPW'(2),
  parameter logic [OPW-1:0]  OP_LDD = OPW'(3)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [STEPW-1:0] step,
  input  logic [OPW-1:0]   opcode,
  input  logic             memReady,
  output strobes_t         st
);
  localparam logic [STEPW-1:0] S_ISSUE  = STEPW'(1);
  localparam logic [STEPW-1:0] S_PCWAIT = STEPW'(2);
  localparam logic [STEPW-1:0] S_IRLOAD = STEPW'(3);
  localparam logic [STEPW-1:0] S_EXEC0  = STEPW'(4);

  logic [STEPW-1:0] execIdx;
  assign execIdx = step - S_EXEC0;

  always_comb begin
    st = '0;
    if (step == S_ISSUE) begin
      st.drv[DRV_PC]  = 1'b1;
      st.load[LD_MAR] = 1'b1;
      st.load[LD_Z]   = 1'b1;
      st.memRead      = 1'b1;
      st.alu          = ALU_INC;
    end else if (step == S_PCWAIT) begin
      st.drv[DRV_Z]   = 1'b1;
      st.load[LD_PC]  = 1'b1;
      st.hold         = !memReady;
    end else if (step == S_IRLOAD) begin
      st.drv[DRV_MDR] = 1'b1;
      st.load[LD_IR]  = 1'b1;
    end else if (opcode == OP_MOV) begin
      st.drv[DRV_SRC]  = 1'b1;
      st.load[LD_DST]  = 1'b1;
      st.stepEnd       = 1'b1;
    end else if (opcode == OP_ADD) begin
      case (execIdx)
        STEPW'(0): begin
          st.drv[DRV_DST] = 1'b1;
          st.load[LD_Y]   = 1'b1;
        end
        STEPW'(1): begin
          st.drv[DRV_SRC] = 1'b1;
          st.load[LD_Z]   = 1'b1;
          st.alu          = ALU_ADD;
        end
        default: begin
          st.drv[DRV_Z]   = 1'b1;
          st.load[LD_DST] = 1'b1;
          st.stepEnd      = 1'b1;
        end
      endcase
    end else if (opcode == OP_LDD) begin
      case (execIdx)
        STEPW'(0): begin
          st.drv[DRV_ADDR] = 1'b1;
          st.load[LD_MAR]  = 1'b1;
          st.memRead       = 1'b1;
        end
        STEPW'(1): st.hold = !memReady;
        default: begin
          st.drv[DRV_MDR] = 1'b1;
          st.load[LD_DST] = 1'b1;
          st.stepEnd      = 1'b1;
        end
      endcase
    end else begin
      st.stepEnd = 1'b1;
    end
  end

  AST_BUS_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(st.drv)); // R9
  AST_READ_ADDR: assert property (@(posedge clk) disable iff (rst)
    st.memRead |-> st.load[LD_MAR]); // R2
  AST_HOLD_NOT_END: assert property (@(posedge clk) disable iff (rst)
    st.hold |-> !st.stepEnd && !memReady); // R7
endmodule

// File: rtl/bus_seq_top.sv
module bus_seq_top
  import ctrl_pkg::*;
#(
  parameter int OPW   = 4,
  parameter int STEPW = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [OPW-1:0]   opcode,
  input  logic             memReady,
  output logic [5:0]       busDrv,
  output logic [5:0]       loadEn,
  output logic             memRead,
  output logic [1:0]       aluOp,
  output logic             waitMem,
  output logic             stepEnd,
  output logic [STEPW-1:0] curStep
);
  strobes_t rawSt;
  strobes_t outSt;
  logic [STEPW-1:0] step;

  step_counter #(.STEPW(STEPW)) u_counter (
    .clk(clk), .rst(rst), .hold(rawSt.hold), .stepEnd(rawSt.stepEnd), .step(step)
  );

  step_decoder #(.OPW(OPW), .STEPW(STEPW)) u_decoder (
    .clk(clk), .rst(rst), .step(step), .opcode(opcode),
    .memReady(memReady), .st(rawSt)
  );

  assign outSt   = rst ? '0 : rawSt;
  assign busDrv  = outSt.drv;
  assign loadEn  = outSt.load;
  assign memRead = outSt.memRead;
  assign aluOp   = outSt.alu;
  assign waitMem = outSt.hold;
  assign stepEnd = outSt.stepEnd;
  assign curStep = step;

  AST_RESET_QUIET: assert property (@(posedge clk)
    rst |-> (busDrv == '0 && loadEn == '0 && !memRead && !stepEnd)); // R1
endmodule

// File: tb/bus_seq_top_bench.sv
module bus_seq_top_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] opcode = 4'd0;
  logic       memReady = 1'b0;
  logic [5:0] busDrv, loadEn;
  logic       memRead, waitMem, stepEnd;
  logic [1:0] aluOp;
  logic [2:0] curStep;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #5 clk = ~clk;

  bus_seq_top u_bus_seq_top (
    .clk(clk), .rst(rst), .opcode(opcode), .memReady(memReady),
    .busDrv(busDrv), .loadEn(loadEn), .memRead(memRead), .aluOp(aluOp),
    .waitMem(waitMem), .stepEnd(stepEnd), .curStep(curStep)
  );

  // model state
  int mStep;
  int mOp;
  int progIdx;
  int cyc;
  bit prevEnd;

  function automatic int progOp(int i);
    case (i % 10)
      0: return 1; 1: return 2; 2: return 3; 3: return 0; 4: return 9;
      5: return 3; 6: return 2; 7: return 1; 8: return 15; default: return 3;
    endcase
  endfunction

  function automatic bit readyPat(int mode, int c);
    if (mode == 0) return 1'b1;
    if (mode == 1) return (c % 3) == 0;
    return (c % 6) == 5;
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h (step %0d op %0d)", tag, act, exp, mStep, mOp);
    end
  endtask

  // behavioural expectation for the current cycle
  task automatic oneCycle();
    logic [5:0] eDrv, eLd;
    logic eRd, eWait, eEnd;
    logic [1:0] eAlu;
    string tag;
    eDrv = 0; eLd = 0; eRd = 0; eWait = 0; eEnd = 0; eAlu = 0;
    #1;
    if (prevEnd) check("R10 restart", 32'(curStep), 32'd1);
    if (mStep == 1) begin
      tag = "R2 fetch issue"; eDrv[0] = 1; eLd[1] = 1; eLd[4] = 1; eRd = 1; eAlu = 2;
    end else if (mStep == 2) begin
      tag = "R3 pc update/wait"; eDrv[2] = 1; eLd[0] = 1; eWait = !memReady;
    end else if (mStep == 3) begin
      tag = "R4 ir load"; eDrv[1] = 1; eLd[2] = 1;
    end else if (mOp == 1) begin
      tag = "R5 move"; eDrv[3] = 1; eLd[5] = 1; eEnd = 1;
    end else if (mOp == 2) begin
      tag = "R6 add";
      if (mStep == 4) begin eDrv[4] = 1; eLd[3] = 1; end
      else if (mStep == 5) begin eDrv[3] = 1; eLd[4] = 1; eAlu = 1; end
      else begin eDrv[2] = 1; eLd[5] = 1; eEnd = 1; end
    end else if (mOp == 3) begin
      tag = "R7 direct load";
      if (mStep == 4) begin eDrv[5] = 1; eLd[1] = 1; eRd = 1; end
      else if (mStep == 5) eWait = !memReady;
      else begin eDrv[1] = 1; eLd[5] = 1; eEnd = 1; end
    end else begin
      tag = "R8 undefined no-op"; eEnd = 1;
    end
    check({tag, " step"}, 32'(curStep), 32'(mStep));
    check({tag, " busDrv"}, 32'(busDrv), 32'(eDrv));
    check({tag, " loadEn"}, 32'(loadEn), 32'(eLd));
    check({tag, " memRead/waitMem/stepEnd"}, {29'd0, memRead, waitMem, stepEnd}, {29'd0, eRd, eWait, eEnd});
    check("R11 aluOp", 32'(aluOp), 32'(eAlu));
    check("R9 bus one driver", 32'($countones(busDrv) <= 1), 32'd1);
    prevEnd = eEnd;
    if (eEnd) mStep = 1;
    else if (!eWait) begin
      if (mStep == 3) begin mOp = progOp(progIdx); progIdx++; end
      mStep = mStep + 1;
    end
  endtask

  task automatic doReset();
    rst = 1'b1;
    @(posedge clk); @(negedge clk); #1;
    check("R1 reset step", 32'(curStep), 32'd1);
    check("R1 reset strobes", {16'd0, busDrv, loadEn, memRead, aluOp, waitMem, stepEnd},
          32'd0);
    @(posedge clk); @(negedge clk);
    rst = 1'b0;
    mStep = 1; prevEnd = 0;
  endtask

  initial begin
    mOp = 0; progIdx = 0; cyc = 0; prevEnd = 0; mStep = 1;
    @(negedge clk);
    doReset();
    for (int mode = 0; mode < 3; mode++) begin
      for (int k = 0; k < 150; k++) begin
        memReady = readyPat(mode, cyc);
        opcode = 4'(mOp);
        oneCycle();
        cyc++;
        @(negedge clk);
        if (mode == 1 && k == 77) doReset();
      end
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule